// File: doc/BRIEF.md
# Command Check and Interrupt Controller

This block sits beside a serial flash/peripheral host engine and checks every command segment at the moment software submits it. It also watches the accesses made to the transmit and receive data queues. Each fault it finds is latched in a sticky error status vector. That vector stays set until software writes a one to the matching bit. While any error is pending, no new command is accepted.

The block also turns queue and engine status into two interrupt lines: one for errors and one for events. Some events fire on a status transition: the receive queue becoming full, the transmit queue becoming empty, the engine becoming ready, or the engine going idle. Others hold for as long as a queue depth sits on the wrong side of its watermark. Each interrupt has a write-one-to-clear state bit, an enable, and a test input that forces the state bit. Register decoding, the queues themselves and the serial engine are outside the block.

Top module: `cmdchk_irq_ctrl`

## Requirements
- R1: A command strobe while `ready_i` is low sets error bit 0 (busy) on the next clock edge.
- R2: A command whose speed field is 3 sets error bit 3 (invalid command). So does a command with direction 3 (both ways) at any speed other than 0. Speed 0 with direction 3 is legal.
- R3: A command whose chip-select ID is greater than or equal to `NUM_CS` (default 4) sets error bit 4. IDs below `NUM_CS` are legal.
- R4: A transmit write while the transmit queue is full sets error bit 1. A receive read while the receive queue is empty sets error bit 2. A receive read from a non-empty queue sets nothing.
- R5: A transmit write with all byte enables low sets error bit 5 (empty access).
- R6: Error bits stay set until a 1 is written to the same position of `err_clr_i`. A set in the same cycle as a clear wins.
- R7: The error enable resets to 0x1f and loads from `err_en_wdata_i` when `err_en_we_i` is high. Enable bit k masks error bit k for k = 0..4. Error bit 5 is always enabled. The error interrupt source is high while any enabled error bit is set.
- R8: Event enable bits select the edge events: bit 0 is a rise of `rx_full_i`, bit 1 a rise of `tx_empty_i`, bit 4 a rise of `ready_i`, and bit 5 a fall of `active_i`. Each selected event sets the event interrupt state one edge after the transition. A level that holds without a new transition does not set it again.
- R9: Event enable bit 2 makes the event source hold while `rx_depth_i > rx_wm_i`. Bit 3 makes it hold while `tx_depth_i < tx_wm_i`. Clearing the state bit while the condition holds sets it again.
- R10: The interrupt state bits are bit 0 for error and bit 1 for event. They clear by writing 1 to `intr_clr_i` and are forced to 1 by `intr_test_i`. Each output line is its state bit ANDed with its enable.
- R11: `cmd_accept_o` is high only during a command strobe that has no busy, invalid or chip-select fault, with no error bit pending.
- R12: After reset, the error status and interrupt state are zero, the error enable is 0x1f, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command submit strobe |
| cmd_speed_i | input | 2 | Command lane speed (0 single, 1 dual, 2 quad, 3 reserved) |
| cmd_dir_i | input | 2 | Command direction (0 dummy, 1 rx, 2 tx, 3 both) |
| cmd_csid_i | input | CSID_W | Target chip-select index |
| ready_i | input | 1 | Engine can take a command |
| active_i | input | 1 | Engine is executing a command |
| tx_full_i | input | 1 | Transmit queue full |
| tx_empty_i | input | 1 | Transmit queue empty |
| rx_full_i | input | 1 | Receive queue full |
| rx_empty_i | input | 1 | Receive queue empty |
| tx_depth_i | input | DEPTH_W | Transmit queue word count |
| rx_depth_i | input | DEPTH_W | Receive queue word count |
| tx_wm_i | input | WM_W | Transmit watermark |
| rx_wm_i | input | WM_W | Receive watermark |
| tx_we_i | input | 1 | Transmit data write strobe |
| tx_be_i | input | BE_W | Byte enables of the transmit write |
| rx_re_i | input | 1 | Receive data read strobe |
| err_en_we_i | input | 1 | Load strobe for the error enable |
| err_en_wdata_i | input | 5 | New error enable value |
| err_clr_i | input | 6 | Write-one-to-clear mask for error status |
| evt_en_i | input | 6 | Event enable mask |
| intr_en_i | input | 2 | Interrupt line enables |
| intr_clr_i | input | 2 | Write-one-to-clear mask for interrupt state |
| intr_test_i | input | 2 | Force interrupt state bits |
| err_status_o | output | 6 | Sticky error status |
| err_en_o | output | 5 | Current error enable |
| intr_state_o | output | 2 | Interrupt state bits |
| cmd_accept_o | output | 1 | The current command strobe is accepted |
| irq_error_o | output | 1 | Error interrupt line |
| irq_event_o | output | 1 | Event interrupt line |

## Verification
The assertions assume the strobes are single-cycle pulses sampled at the rising edge. They also assume the status flags from the queues and the engine are clean synchronous levels, so a transition seen by the edge checks is a real one. The stimulus changes every input only on the falling clock edge. It holds the flags at idle values through reset, so the edge detector starts matched to its inputs. Each scenario clears all error and interrupt state before the next one starts, so the effects of one scenario do not carry into the next.

// File: rtl/cmdchk_pkg.sv
package cmdchk_pkg;

    localparam int ERR_W = 6;
    localparam int EVT_W = 6;
    localparam int IRQ_W = 2;

    localparam int ERR_BUSY   = 0;
    localparam int ERR_OVFL   = 1;
    localparam int ERR_UNFL   = 2;
    localparam int ERR_CMDBAD = 3;
    localparam int ERR_CSBAD  = 4;
    localparam int ERR_NOBYTE = 5;

    localparam int EV_RXFULL  = 0;
    localparam int EV_TXEMPTY = 1;
    localparam int EV_RXWM    = 2;
    localparam int EV_TXWM    = 3;
    localparam int EV_READY   = 4;
    localparam int EV_IDLE    = 5;

    localparam int IRQ_ERR = 0;
    localparam int IRQ_EVT = 1;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'd0,
        SPD_DUAL   = 2'd1,
        SPD_QUAD   = 2'd2,
        SPD_RSVD   = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        DIR_DUMMY = 2'd0,
        DIR_RX    = 2'd1,
        DIR_TX    = 2'd2,
        DIR_BOTH  = 2'd3
    } dir_e;

    typedef struct packed {
        logic rx_full;
        logic tx_empty;
        logic ready;
        logic active;
    } flag_hist_t;

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic [ERR_W-2:0] en;
    } err_regs_t;

endpackage

// File: rtl/cmdchk_classify.sv
module cmdchk_classify
    import cmdchk_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CSID_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              cmd_we_i,
    input  logic [1:0]        cmd_speed_i,
    input  logic [1:0]        cmd_dir_i,
    input  logic [CSID_W-1:0] cmd_csid_i,
    input  logic              ready_i,
    input  logic              tx_we_i,
    input  logic [BE_W-1:0]   tx_be_i,
    input  logic              tx_full_i,
    input  logic              rx_re_i,
    input  logic              rx_empty_i,
    output logic [ERR_W-1:0]  set_o,
    output logic              cmd_clean_o
);

    localparam logic [CSID_W:0] CS_LIMIT = (CSID_W+1)'(NUM_CS);

    speed_e speed;
    dir_e   dir;
    logic   bad_shape;
    logic   bad_csid;

    always_comb begin
        speed     = speed_e'(cmd_speed_i);
        dir       = dir_e'(cmd_dir_i);
        bad_shape = (speed == SPD_RSVD) || ((dir == DIR_BOTH) && (speed != SPD_SINGLE));
        bad_csid  = ({1'b0, cmd_csid_i} >= CS_LIMIT);

        set_o             = '0;
        set_o[ERR_BUSY]   = cmd_we_i && !ready_i;
        set_o[ERR_CMDBAD] = cmd_we_i && bad_shape;
        set_o[ERR_CSBAD]  = cmd_we_i && bad_csid;
        set_o[ERR_OVFL]   = tx_we_i && tx_full_i;
        set_o[ERR_UNFL]   = rx_re_i && rx_empty_i;
        set_o[ERR_NOBYTE] = tx_we_i && (tx_be_i == '0);

        cmd_clean_o = ready_i && !bad_shape && !bad_csid;
    end

endmodule

// File: rtl/cmdchk_evt_detect.sv
module cmdchk_evt_detect
    import cmdchk_pkg::*;
#(
    parameter int DEPTH_W = 8,
    parameter int WM_W    = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               rx_full_i,
    input  logic               tx_empty_i,
    input  logic               ready_i,
    input  logic               active_i,
    input  logic [DEPTH_W-1:0] rx_depth_i,
    input  logic [DEPTH_W-1:0] tx_depth_i,
    input  logic [WM_W-1:0]    rx_wm_i,
    input  logic [WM_W-1:0]    tx_wm_i,
    input  logic [EVT_W-1:0]   evt_en_i,
    output logic               evt_hit_o
);

    localparam int CMP_W = (DEPTH_W > WM_W) ? DEPTH_W : WM_W;
    localparam flag_hist_t HIST_RST = '{rx_full: 1'b0, tx_empty: 1'b1, ready: 1'b1, active: 1'b0};

    flag_hist_t hist_d, hist_q;
    logic [EVT_W-1:0] cond;

    always_comb begin
        hist_d.rx_full  = rx_full_i;
        hist_d.tx_empty = tx_empty_i;
        hist_d.ready    = ready_i;
        hist_d.active   = active_i;

        cond             = '0;
        cond[EV_RXFULL]  = rx_full_i && !hist_q.rx_full;
        cond[EV_TXEMPTY] = tx_empty_i && !hist_q.tx_empty;
        cond[EV_READY]   = ready_i && !hist_q.ready;
        cond[EV_IDLE]    = !active_i && hist_q.active;
        cond[EV_RXWM]    = CMP_W'(rx_depth_i) > CMP_W'(rx_wm_i);
        cond[EV_TXWM]    = CMP_W'(tx_depth_i) < CMP_W'(tx_wm_i);

        evt_hit_o = |(cond & evt_en_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= HIST_RST;
        else         hist_q <= hist_d;
    end

    a_r8_rxfull_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_en_i[EV_RXFULL] && rx_full_i && !$past(rx_full_i)) |-> evt_hit_o);
    a_r8_idle_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_en_i[EV_IDLE] && !active_i && $past(active_i)) |-> evt_hit_o);
    a_r9_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_en_i == '0) |-> !evt_hit_o);

endmodule

// File: rtl/cmdchk_intr_bank.sv
module cmdchk_intr_bank #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] test_i,
    output logic [N-1:0] state_o,
    output logic [N-1:0] irq_o
);

    logic [N-1:0] state_d, state_q;

    always_comb begin
        state_d = (state_q & ~clr_i) | src_i | test_i;
        irq_o   = state_q & en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign state_o = state_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r10_test_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
            test_i[i] |=> state_o[i]);
        a_r10_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[i] && !src_i[i] && !test_i[i]) |=> !state_o[i]);
        a_r10_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[i] |-> (en_i[i] && state_o[i]));
    end

endmodule

// File: rtl/cmdchk_irq_ctrl.sv
module cmdchk_irq_ctrl
    import cmdchk_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int CSID_W  = 32,
    parameter int DEPTH_W = 8,
    parameter int WM_W    = 8,
    parameter int BE_W    = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cmd_we_i,
    input  logic [1:0]         cmd_speed_i,
    input  logic [1:0]         cmd_dir_i,
    input  logic [CSID_W-1:0]  cmd_csid_i,
    input  logic               ready_i,
    input  logic               active_i,
    input  logic               tx_full_i,
    input  logic               tx_empty_i,
    input  logic               rx_full_i,
    input  logic               rx_empty_i,
    input  logic [DEPTH_W-1:0] tx_depth_i,
    input  logic [DEPTH_W-1:0] rx_depth_i,
    input  logic [WM_W-1:0]    tx_wm_i,
    input  logic [WM_W-1:0]    rx_wm_i,
    input  logic               tx_we_i,
    input  logic [BE_W-1:0]    tx_be_i,
    input  logic               rx_re_i,
    input  logic               err_en_we_i,
    input  logic [4:0]         err_en_wdata_i,
    input  logic [5:0]         err_clr_i,
    input  logic [5:0]         evt_en_i,
    input  logic [1:0]         intr_en_i,
    input  logic [1:0]         intr_clr_i,
    input  logic [1:0]         intr_test_i,
    output logic [5:0]         err_status_o,
    output logic [4:0]         err_en_o,
    output logic [1:0]         intr_state_o,
    output logic               cmd_accept_o,
    output logic               irq_error_o,
    output logic               irq_event_o
);

    localparam err_regs_t REGS_RST = '{err: '0, en: '1};

    err_regs_t        regs_d, regs_q;
    logic [ERR_W-1:0] err_set;
    logic             cmd_clean;
    logic             evt_hit;
    logic             err_src;
    logic [IRQ_W-1:0] irq_src;
    logic [IRQ_W-1:0] irq_line;

    cmdchk_classify #(
        .NUM_CS (NUM_CS),
        .CSID_W (CSID_W),
        .BE_W   (BE_W)
    ) u_classify (
        .cmd_we_i    (cmd_we_i),
        .cmd_speed_i (cmd_speed_i),
        .cmd_dir_i   (cmd_dir_i),
        .cmd_csid_i  (cmd_csid_i),
        .ready_i     (ready_i),
        .tx_we_i     (tx_we_i),
        .tx_be_i     (tx_be_i),
        .tx_full_i   (tx_full_i),
        .rx_re_i     (rx_re_i),
        .rx_empty_i  (rx_empty_i),
        .set_o       (err_set),
        .cmd_clean_o (cmd_clean)
    );

    cmdchk_evt_detect #(
        .DEPTH_W (DEPTH_W),
        .WM_W    (WM_W)
    ) u_evt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rx_full_i  (rx_full_i),
        .tx_empty_i (tx_empty_i),
        .ready_i    (ready_i),
        .active_i   (active_i),
        .rx_depth_i (rx_depth_i),
        .tx_depth_i (tx_depth_i),
        .rx_wm_i    (rx_wm_i),
        .tx_wm_i    (tx_wm_i),
        .evt_en_i   (evt_en_i),
        .evt_hit_o  (evt_hit)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.err = (regs_q.err & ~err_clr_i) | err_set;
        if (err_en_we_i) regs_d.en = err_en_wdata_i;

        err_src          = |(regs_q.err & {1'b1, regs_q.en});
        irq_src          = '0;
        irq_src[IRQ_ERR] = err_src;
        irq_src[IRQ_EVT] = evt_hit;

        cmd_accept_o = cmd_we_i && cmd_clean && (regs_q.err == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= REGS_RST;
        else         regs_q <= regs_d;
    end

    cmdchk_intr_bank #(
        .N (IRQ_W)
    ) u_intr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .src_i   (irq_src),
        .en_i    (intr_en_i),
        .clr_i   (intr_clr_i),
        .test_i  (intr_test_i),
        .state_o (intr_state_o),
        .irq_o   (irq_line)
    );

    assign err_status_o = regs_q.err;
    assign err_en_o     = regs_q.en;
    assign irq_error_o  = irq_line[IRQ_ERR];
    assign irq_event_o  = irq_line[IRQ_EVT];

    a_r1_busy_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && !ready_i) |=> err_status_o[ERR_BUSY]);
    a_r2_bad_speed_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && cmd_speed_i == 2'd3) |=> err_status_o[ERR_CMDBAD]);
    a_r3_csid_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && cmd_csid_i >= CSID_W'(NUM_CS)) |=> err_status_o[ERR_CSBAD]);
    a_r4_overflow_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_we_i && tx_full_i) |=> err_status_o[ERR_OVFL]);
    a_r4_underflow_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_re_i && rx_empty_i) |=> err_status_o[ERR_UNFL]);
    a_r5_nobyte_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_we_i && tx_be_i == '0) |=> err_status_o[ERR_NOBYTE]);
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(err_status_o & ~err_clr_i)) |=>
        ((err_status_o & $past(err_status_o & ~err_clr_i)) == $past(err_status_o & ~err_clr_i)));
    a_r11_accept_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_accept_o |=> !err_status_o[ERR_BUSY] && !err_status_o[ERR_CMDBAD] && !err_status_o[ERR_CSBAD]);
    a_r11_pending_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_status_o != '0) |-> !cmd_accept_o);

endmodule

// File: tb/cmdchk_irq_ctrl_tb_top.sv
module cmdchk_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_we;
    logic [1:0]  cmd_speed, cmd_dir;
    logic [31:0] cmd_csid;
    logic        ready, active, tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]  tx_depth, rx_depth, tx_wm, rx_wm;
    logic        tx_we, rx_re, err_en_we;
    logic [3:0]  tx_be;
    logic [4:0]  err_en_wdata, err_en;
    logic [5:0]  err_clr, evt_en, err_status;
    logic [1:0]  intr_en, intr_clr, intr_test, intr_state;
    logic        cmd_accept, irq_error, irq_event;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    cmdchk_irq_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cmd_we_i(cmd_we), .cmd_speed_i(cmd_speed), .cmd_dir_i(cmd_dir), .cmd_csid_i(cmd_csid),
        .ready_i(ready), .active_i(active),
        .tx_full_i(tx_full), .tx_empty_i(tx_empty), .rx_full_i(rx_full), .rx_empty_i(rx_empty),
        .tx_depth_i(tx_depth), .rx_depth_i(rx_depth), .tx_wm_i(tx_wm), .rx_wm_i(rx_wm),
        .tx_we_i(tx_we), .tx_be_i(tx_be), .rx_re_i(rx_re),
        .err_en_we_i(err_en_we), .err_en_wdata_i(err_en_wdata), .err_clr_i(err_clr),
        .evt_en_i(evt_en), .intr_en_i(intr_en), .intr_clr_i(intr_clr), .intr_test_i(intr_test),
        .err_status_o(err_status), .err_en_o(err_en), .intr_state_o(intr_state),
        .cmd_accept_o(cmd_accept), .irq_error_o(irq_error), .irq_event_o(irq_event)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        err_clr = 6'h3f; step(); err_clr = '0;
        intr_clr = 2'b11; step(); intr_clr = '0;
    endtask

    task automatic send_cmd(logic [1:0] spd, logic [1:0] dir, logic [31:0] cs);
        cmd_speed = spd; cmd_dir = dir; cmd_csid = cs; cmd_we = 1'b1;
        step();
        cmd_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 err_status", err_status, 0);
        chk("R12 err_en", err_en, 5'h1f);
        chk("R12 intr_state", intr_state, 0);
        chk("R12 irq lines", {irq_error, irq_event}, 0);
    endtask

    task automatic t_accept();
        cmd_speed = 2'd2; cmd_dir = 2'd1; cmd_csid = 1; cmd_we = 1'b1;
        #1 chk("R11 valid cmd accepted", cmd_accept, 1);
        step(); cmd_we = 1'b0;
        chk("R11 no error after valid cmd", err_status, 0);
    endtask

    task automatic t_busy();
        ready = 1'b0;
        cmd_speed = 2'd0; cmd_dir = 2'd2; cmd_csid = 0; cmd_we = 1'b1;
        #1 chk("R11 busy cmd refused", cmd_accept, 0);
        step(); cmd_we = 1'b0; ready = 1'b1;
        chk("R1 busy bit", err_status, 6'h01);
        step();
        chk("R6 busy bit sticky", err_status, 6'h01);
        cmd_we = 1'b1;
        #1 chk("R11 pending error blocks", cmd_accept, 0);
        step(); cmd_we = 1'b0;
        err_clr = 6'h01; step(); err_clr = '0;
        chk("R6 w1c clears", err_status, 0);
        clear_all();
    endtask

    task automatic t_invalid();
        send_cmd(2'd3, 2'd0, 0);
        chk("R2 reserved speed", err_status, 6'h08);
        clear_all();
        send_cmd(2'd1, 2'd3, 0);
        chk("R2 bidir at dual", err_status, 6'h08);
        clear_all();
        send_cmd(2'd0, 2'd3, 0);
        chk("R2 bidir at single legal", err_status, 0);
        clear_all();
    endtask

    task automatic t_csid();
        send_cmd(2'd0, 2'd1, 4);
        chk("R3 csid 4 invalid", err_status, 6'h10);
        clear_all();
        send_cmd(2'd0, 2'd1, 3);
        chk("R3 csid 3 legal", err_status, 0);
        clear_all();
    endtask

    task automatic t_queues();
        tx_full = 1'b1; tx_be = 4'hf; tx_we = 1'b1; step(); tx_we = 1'b0; tx_full = 1'b0;
        chk("R4 overflow", err_status, 6'h02);
        clear_all();
        rx_re = 1'b1; step(); rx_re = 1'b0;
        chk("R4 underflow", err_status, 6'h04);
        clear_all();
        rx_empty = 1'b0; rx_re = 1'b1; step(); rx_re = 1'b0; rx_empty = 1'b1;
        chk("R4 read non-empty ok", err_status, 0);
        clear_all();
        tx_be = 4'h0; tx_we = 1'b1; step(); tx_we = 1'b0; tx_be = 4'hf;
        chk("R5 zero byte write", err_status, 6'h20);
        clear_all();
    endtask

    task automatic t_err_irq();
        intr_en = 2'b01;
        tx_full = 1'b1; tx_we = 1'b1; step(); tx_we = 1'b0; tx_full = 1'b0;
        step();
        chk("R7 error state", intr_state, 2'b01);
        chk("R10 error line", irq_error, 1);
        err_clr = 6'h02; intr_clr = 2'b01; step(); err_clr = '0; intr_clr = '0;
        chk("R6 overflow cleared", err_status, 0);
        chk("R7 source held during clear", intr_state, 2'b01);
        intr_clr = 2'b01; step(); intr_clr = '0;
        chk("R10 error state cleared", intr_state, 0);
        err_en_wdata = 5'h1d; err_en_we = 1'b1; step(); err_en_we = 1'b0;
        chk("R7 enable load", err_en, 5'h1d);
        tx_full = 1'b1; tx_we = 1'b1; step(); tx_we = 1'b0; tx_full = 1'b0;
        step();
        chk("R7 masked overflow", {intr_state, irq_error}, 0);
        err_clr = 6'h02; step(); err_clr = '0;
        tx_be = 4'h0; tx_we = 1'b1; step(); tx_we = 1'b0; tx_be = 4'hf;
        step();
        chk("R7 empty access unmasked", intr_state, 2'b01);
        clear_all();
        err_en_wdata = 5'h1f; err_en_we = 1'b1; step(); err_en_we = 1'b0;
        intr_en = 2'b00;
    endtask

    task automatic t_edges();
        intr_en = 2'b10;
        evt_en = 6'h01; rx_full = 1'b1; step();
        chk("R8 rx full rise", {intr_state, irq_event}, {2'b10, 1'b1});
        intr_clr = 2'b10; step(); intr_clr = '0;
        chk("R8 no refire on level", intr_state, 0);
        rx_full = 1'b0; step();
        evt_en = 6'h00; ready = 1'b0; step(); ready = 1'b1; step();
        chk("R8 disabled ready rise", intr_state, 0);
        evt_en = 6'h10; ready = 1'b0; step(); ready = 1'b1; step();
        chk("R8 ready rise", intr_state, 2'b10);
        clear_all();
        evt_en = 6'h20; active = 1'b1; step();
        chk("R8 active rise ignored", intr_state, 0);
        active = 1'b0; step();
        chk("R8 active fall", intr_state, 2'b10);
        clear_all();
        evt_en = 6'h02; tx_empty = 1'b0; step(); tx_empty = 1'b1; step();
        chk("R8 tx empty rise", intr_state, 2'b10);
        clear_all();
        evt_en = 0; intr_en = 0;
    endtask

    task automatic t_watermark();
        evt_en = 6'h04; rx_wm = 8'd3; rx_depth = 8'd3; step(); step();
        chk("R9 rx depth equal wm", intr_state, 0);
        rx_depth = 8'd4; step();
        chk("R9 rx above wm", intr_state, 2'b10);
        intr_clr = 2'b10; step(); intr_clr = '0;
        chk("R9 level re-sets", intr_state, 2'b10);
        rx_depth = 8'd0; intr_clr = 2'b10; step(); intr_clr = '0;
        chk("R9 rx cleared", intr_state, 0);
        evt_en = 6'h08; tx_wm = 8'd2; tx_depth = 8'd2; step(); step();
        chk("R9 tx depth equal wm", intr_state, 0);
        tx_depth = 8'd1; step();
        chk("R9 tx below wm", intr_state, 2'b10);
        tx_depth = 8'd2; intr_clr = 2'b10; step(); intr_clr = '0;
        chk("R9 tx cleared", intr_state, 0);
        evt_en = 0; tx_wm = 0; tx_depth = 0; rx_wm = 8'h7f;
    endtask

    task automatic t_test();
        intr_en = 2'b00; intr_test = 2'b10; step(); intr_test = '0;
        chk("R10 test forces state", intr_state, 2'b10);
        chk("R10 line gated off", irq_event, 0);
        intr_en = 2'b10;
        #1 chk("R10 line enabled", irq_event, 1);
        intr_clr = 2'b10; step(); intr_clr = '0;
        chk("R10 test state cleared", intr_state, 0);
        intr_en = 0;
    endtask

    initial begin
        rst_n = 1'b0;
        cmd_we = 0; cmd_speed = 0; cmd_dir = 0; cmd_csid = 0;
        ready = 1; active = 0; tx_full = 0; tx_empty = 1; rx_full = 0; rx_empty = 1;
        tx_depth = 0; rx_depth = 0; tx_wm = 0; rx_wm = 8'h7f;
        tx_we = 0; tx_be = 4'hf; rx_re = 0;
        err_en_we = 0; err_en_wdata = 0; err_clr = 0; evt_en = 0;
        intr_en = 0; intr_clr = 0; intr_test = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_accept();
        t_busy();
        t_invalid();
        t_csid();
        t_queues();
        t_err_irq();
        t_edges();
        t_watermark();
        t_test();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule